// File: doc/BRIEF.md
# Programmed I/O Transfer Controller

This block carries out the input/output transfer instructions of a 12-bit accumulator machine. Each cycle it may be handed one instruction word with a one-cycle valid strobe, the current accumulator, and the ready flags and input characters of four simple character devices. One cycle later it returns a skip request, the new accumulator value, a transfer strobe and a ready-clear pulse for the addressed device, the outgoing character, and a decoded function for any other device. It also holds the processor's interrupt-enable state.

The opcode sits in the top three bits of the word, and the value 110 selects this class. The next six bits name one of 64 devices. The low three bits are the function.

Device 0 is processor control and is never routed to a device. Devices 1 to 4 are simple devices: 1 and 3 deliver characters, and 2 and 4 accept them. Their function bits act as micro-operations and run in a fixed order: the ready test first, then the accumulator clear, then the transfer. Every other device gets the function as a one-hot code of eight lines.

Top module: `iot_xfer_ctrl`

## Requirements
- R1: After reset, every output is 0 and interrupt enable is off.
- R2: An instruction whose opcode bits [11:9] are not 110 has no effect. resultValid stays 0, no strobe or decoded-function pulse is raised, and interrupt enable keeps its value.
- R3: Word 6001 (octal) turns interrupt enable on and 6002 turns it off. Any other device-0 function leaves it unchanged. A device-0 word never raises a device strobe, a ready-clear or genValid.
- R4: For a simple device (device field [8:3] equal to 1..4, lane = device-1), function bit [0] raises skipReq when devReady[lane] is 1. In every other case skipReq is 0.
- R5: For a simple device, function bit [1] clears the accumulator before any transfer.
- R6: For an input device (1 or 3), function bit [2] ORs the lane's 8-bit character, devInData[lane*8 +: 8], into the low bits of the accumulator after the clear step.
- R7: For an output device (2 or 4), function bit [2] drives outData with the low 8 bits of the accumulator after the clear step, so it is 0 when bit [1] is also set. The accumulator is then left unchanged unless bit [1] is set. outData holds its value otherwise.
- R8: For a simple device, function bit [2] pulses devStrobe[lane] and readyClr[lane] for exactly one cycle. No other lane pulses.
- R9: For devices 5..63, genValid pulses, genDev carries the device number and genFunc has exactly bit [function] set. In this case acOut equals acIn and skipReq is 0.
- R10: All results are registered. They appear on the cycle after instValid, with resultValid high for that single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | One-cycle instruction strobe |
| instWord | input | 12 | Instruction word |
| acIn | input | 12 | Accumulator before the instruction |
| devReady | input | 4 | Ready flags of simple devices 1..4 |
| devInData | input | 32 | Input characters, 8 bits per simple device lane |
| resultValid | output | 1 | Results below are valid this cycle |
| skipReq | output | 1 | Skip the next instruction |
| acOut | output | 12 | Accumulator after the instruction |
| devStrobe | output | 4 | Transfer strobe per simple device |
| readyClr | output | 4 | Ready-flag clear per simple device |
| outData | output | 8 | Character sent to an output device |
| genValid | output | 1 | Decoded function for a non-simple device |
| genDev | output | 6 | Device number for the decoded function |
| genFunc | output | 8 | One-hot decoded function |
| intEnable | output | 1 | Interrupt enable state |

## Verification
The bench sweeps every device and function code under three ready patterns. Only the addressed lane ready catches a design that tests the wrong lane's flag. All lanes except the addressed one ready catches a skip taken from any set flag. Clear combined with transfer gets close attention. On an input device the character must land in a cleared accumulator. On an output device the character sent must be zero, and a design that sends first and clears afterwards would put the old accumulator on outData. Device 0 must change only interrupt enable. Words of other opcodes that carry the 6001 or 6002 low bits must be ignored, which exposes a decoder that skips the opcode compare.

// File: rtl/iot_pkg.sv
package iot_pkg;
  localparam int AC_W       = 12;
  localparam int DEV_W      = 6;
  localparam int FUNC_W     = 3;
  localparam int CHAR_W     = 8;
  localparam int NUM_SIMPLE = 4;
  localparam int LANE_W     = $clog2(NUM_SIMPLE);
  localparam int GEN_W      = 1 << FUNC_W;
  localparam logic [2:0] OPC_IOT = 3'b110;

  typedef struct packed {
    logic              fire;
    logic              simple;
    logic              inputDev;
    logic [LANE_W-1:0] lane;
    logic              testSkip;
    logic              clearAc;
    logic              xfer;
    logic              setIe;
    logic              clrIe;
    logic              generic;
  } ctlStrobes_t;
endpackage

// File: rtl/iot_ctrl.sv
module iot_ctrl
  import iot_pkg::*;
#(
  parameter logic [NUM_SIMPLE-1:0] IN_MASK = 4'b0101
) (
  input  logic            instValid,
  input  logic [AC_W-1:0] instWord,
  output ctlStrobes_t     ctl
);
  logic [2:0]        opc;
  logic [DEV_W-1:0]  dev;
  logic [FUNC_W-1:0] fn;
  logic              isIot;
  logic              isSimple;

  assign opc = instWord[AC_W-1 -: 3];
  assign dev = instWord[FUNC_W +: DEV_W];
  assign fn  = instWord[FUNC_W-1:0];

  assign isIot    = instValid && (opc == OPC_IOT);
  assign isSimple = (dev >= DEV_W'(1)) && (dev <= DEV_W'(NUM_SIMPLE));

  always_comb begin
    ctl          = '0;
    ctl.fire     = isIot;
    ctl.simple   = isIot && isSimple;
    ctl.lane     = LANE_W'(dev - DEV_W'(1));
    ctl.inputDev = IN_MASK[ctl.lane];
    // micro-operation order: skip test, clear, transfer
    ctl.testSkip = fn[0];
    ctl.clearAc  = fn[1];
    ctl.xfer     = fn[2];
    ctl.setIe    = isIot && (dev == '0) && (fn == FUNC_W'(1));
    ctl.clrIe    = isIot && (dev == '0) && (fn == FUNC_W'(2));
    ctl.generic  = isIot && (dev > DEV_W'(NUM_SIMPLE));
  end
endmodule

// File: rtl/iot_datapath.sv
module iot_datapath
  import iot_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  ctlStrobes_t                  ctl,
  input  logic [DEV_W-1:0]             devSel,
  input  logic [FUNC_W-1:0]            funcSel,
  input  logic [AC_W-1:0]              acIn,
  input  logic [NUM_SIMPLE-1:0]        devReady,
  input  logic [NUM_SIMPLE*CHAR_W-1:0] devInData,
  output logic                         resultValid,
  output logic                         skipReq,
  output logic [AC_W-1:0]              acOut,
  output logic [NUM_SIMPLE-1:0]        devStrobe,
  output logic [NUM_SIMPLE-1:0]        readyClr,
  output logic [CHAR_W-1:0]            outData,
  output logic                         genValid,
  output logic [DEV_W-1:0]             genDev,
  output logic [GEN_W-1:0]             genFunc,
  output logic                         intEnable
);
  logic [AC_W-1:0]       stepAc;
  logic [AC_W-1:0]       nextAc;
  logic [CHAR_W-1:0]     laneChar;
  logic [NUM_SIMPLE-1:0] laneHot;
  logic                  doXfer;
  logic                  nextSkip;

  always_comb begin
    laneChar = devInData[ctl.lane*CHAR_W +: CHAR_W];
    laneHot  = NUM_SIMPLE'(1) << ctl.lane;
    doXfer   = ctl.simple && ctl.xfer;
    nextSkip = ctl.simple && ctl.testSkip && devReady[ctl.lane];
    stepAc   = (ctl.simple && ctl.clearAc) ? '0 : acIn;
    nextAc   = stepAc;
    if (doXfer && ctl.inputDev) nextAc = stepAc | AC_W'(laneChar);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultValid <= 1'b0;
      skipReq     <= 1'b0;
      acOut       <= '0;
      devStrobe   <= '0;
      readyClr    <= '0;
      outData     <= '0;
      genValid    <= 1'b0;
      genDev      <= '0;
      genFunc     <= '0;
      intEnable   <= 1'b0;
    end else begin
      resultValid <= ctl.fire;
      skipReq     <= nextSkip;
      devStrobe   <= doXfer ? laneHot : '0;
      readyClr    <= doXfer ? laneHot : '0;
      genValid    <= ctl.generic;
      if (ctl.fire) acOut <= nextAc;
      if (doXfer && !ctl.inputDev) outData <= stepAc[CHAR_W-1:0];
      if (ctl.generic) begin
        genDev  <= devSel;
        genFunc <= GEN_W'(1) << funcSel;
      end
      if (ctl.setIe)      intEnable <= 1'b1;
      else if (ctl.clrIe) intEnable <= 1'b0;
    end
  end
endmodule

// File: rtl/iot_xfer_ctrl.sv
module iot_xfer_ctrl
  import iot_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         instValid,
  input  logic [AC_W-1:0]              instWord,
  input  logic [AC_W-1:0]              acIn,
  input  logic [NUM_SIMPLE-1:0]        devReady,
  input  logic [NUM_SIMPLE*CHAR_W-1:0] devInData,
  output logic                         resultValid,
  output logic                         skipReq,
  output logic [AC_W-1:0]              acOut,
  output logic [NUM_SIMPLE-1:0]        devStrobe,
  output logic [NUM_SIMPLE-1:0]        readyClr,
  output logic [CHAR_W-1:0]            outData,
  output logic                         genValid,
  output logic [DEV_W-1:0]             genDev,
  output logic [GEN_W-1:0]             genFunc,
  output logic                         intEnable
);
  ctlStrobes_t ctl;

  iot_ctrl #(.IN_MASK(4'b0101)) u_ctrl (
    .instValid (instValid),
    .instWord  (instWord),
    .ctl       (ctl)
  );

  iot_datapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .devSel      (instWord[FUNC_W +: DEV_W]),
    .funcSel     (instWord[FUNC_W-1:0]),
    .acIn        (acIn),
    .devReady    (devReady),
    .devInData   (devInData),
    .resultValid (resultValid),
    .skipReq     (skipReq),
    .acOut       (acOut),
    .devStrobe   (devStrobe),
    .readyClr    (readyClr),
    .outData     (outData),
    .genValid    (genValid),
    .genDev      (genDev),
    .genFunc     (genFunc),
    .intEnable   (intEnable)
  );
endmodule

// File: rtl/iot_xfer_checker.sv
module iot_xfer_checker
  import iot_pkg::*;
(
  input logic                         clk,
  input logic                         rstN,
  input logic                         instValid,
  input logic [AC_W-1:0]              instWord,
  input logic [AC_W-1:0]              acIn,
  input logic [NUM_SIMPLE-1:0]        devReady,
  input logic [NUM_SIMPLE*CHAR_W-1:0] devInData,
  input logic                         resultValid,
  input logic                         skipReq,
  input logic [AC_W-1:0]              acOut,
  input logic [NUM_SIMPLE-1:0]        devStrobe,
  input logic [NUM_SIMPLE-1:0]        readyClr,
  input logic [CHAR_W-1:0]            outData,
  input logic                         genValid,
  input logic [DEV_W-1:0]             genDev,
  input logic [GEN_W-1:0]             genFunc,
  input logic                         intEnable
);
  logic              isIot;
  logic [DEV_W-1:0]  dev;
  logic              simpleDev;
  logic [LANE_W-1:0] lane;

  assign isIot     = instValid && (instWord[11:9] == 3'b110);
  assign dev       = instWord[8:3];
  assign simpleDev = (dev != '0) && (dev <= DEV_W'(NUM_SIMPLE));
  assign lane      = LANE_W'(dev - DEV_W'(1));

  p_quiet_other_op_r2: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && !isIot) |=> (!resultValid && devStrobe == '0 && !genValid && $stable(intEnable)));

  p_ie_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    (isIot && instWord[8:0] == 9'o001) |=> intEnable);

  p_ie_clr_r3: assert property (@(posedge clk) disable iff (!rstN)
    (isIot && instWord[8:0] == 9'o002) |=> !intEnable);

  p_ie_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !instValid |=> $stable(intEnable));

  p_skip_ready_r4: assert property (@(posedge clk) disable iff (!rstN)
    (isIot && simpleDev && instWord[0] && devReady[lane]) |=> skipReq);

  p_strobe_onehot_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(devStrobe) && (devStrobe == readyClr));

  p_gen_func_r9: assert property (@(posedge clk) disable iff (!rstN)
    genValid |-> ($countones(genFunc) == 1 && !skipReq));

  p_single_cycle_r10: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && !$past(instValid)) |-> 1'b0);
endmodule

bind iot_xfer_ctrl iot_xfer_checker chk (.*);

// File: tb/tb_iot_xfer_ctrl.sv
module tb_iot_xfer_ctrl;
  logic        clk = 1'b0;
  logic        rstN;
  logic        instValid;
  logic [11:0] instWord;
  logic [11:0] acIn;
  logic [3:0]  devReady;
  logic [31:0] devInData;
  logic        resultValid, skipReq, genValid, intEnable;
  logic [11:0] acOut;
  logic [3:0]  devStrobe, readyClr;
  logic [7:0]  outData, genFunc;
  logic [5:0]  genDev;

  int errors = 0;
  int checks = 0;
  logic       ieExp = 1'b0;
  logic [7:0] outExp = 8'h00;

  always #5 clk = ~clk;

  iot_xfer_ctrl dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic runOne(input logic [11:0] word, input logic [11:0] ac, input logic [3:0] rdy);
    logic [2:0]  op;
    logic [5:0]  dev;
    logic [2:0]  fn;
    int          lane;
    bit          simple, isIn;
    logic [11:0] step, expAc;
    logic [7:0]  ch;
    logic [3:0]  expStb;
    bit          expSkip;
    op = word[11:9]; dev = word[8:3]; fn = word[2:0];
    @(negedge clk);
    instWord = word; acIn = ac; devReady = rdy; instValid = 1'b1;
    for (int l = 0; l < 4; l++) devInData[l*8 +: 8] = (ac[7:0] + 8'(l * 49)) ^ 8'hC3;
    @(negedge clk);
    instValid = 1'b0;
    if (op != 3'b110) begin
      chk(resultValid == 1'b0, "R2 resultValid", 32'(resultValid), 0);
      chk(devStrobe == 4'd0 && genValid == 1'b0, "R2 pulses", {devStrobe, 3'b0, genValid}, 0);
      chk(intEnable == ieExp, "R2 intEnable", 32'(intEnable), 32'(ieExp));
    end else begin
      lane = int'(dev) - 1;
      simple = (dev >= 1 && dev <= 4);
      isIn = (dev == 1 || dev == 3);
      ch = simple ? devInData[lane*8 +: 8] : 8'h00;
      expSkip = simple && fn[0] && rdy[lane];
      step = (simple && fn[1]) ? 12'd0 : ac;
      expAc = step | ((simple && fn[2] && isIn) ? {4'd0, ch} : 12'd0);
      expStb = (simple && fn[2]) ? (4'd1 << lane) : 4'd0;
      if (simple && fn[2] && !isIn) outExp = step[7:0];
      if (dev == 0 && fn == 3'd1) ieExp = 1'b1;
      if (dev == 0 && fn == 3'd2) ieExp = 1'b0;
      chk(resultValid == 1'b1, "R10 resultValid", 32'(resultValid), 1);
      chk(acOut == expAc, (simple && fn[2] && isIn) ? "R6 acOut" : "R5 acOut", 32'(acOut), 32'(expAc));
      chk(skipReq == expSkip, "R4 skipReq", 32'(skipReq), 32'(expSkip));
      chk(devStrobe == expStb, "R8 devStrobe", 32'(devStrobe), 32'(expStb));
      chk(readyClr == expStb, "R8 readyClr", 32'(readyClr), 32'(expStb));
      chk(outData == outExp, "R7 outData", 32'(outData), 32'(outExp));
      chk(intEnable == ieExp, "R3 intEnable", 32'(intEnable), 32'(ieExp));
      if (dev > 4) begin
        chk(genValid == 1'b1 && genDev == dev, "R9 genValid/genDev", {genValid, genDev}, {1'b1, dev});
        chk(genFunc == (8'd1 << fn), "R9 genFunc", 32'(genFunc), 32'(8'd1 << fn));
      end else begin
        chk(genValid == 1'b0, "R9 genValid idle", 32'(genValid), 0);
      end
    end
    @(negedge clk);
    chk(resultValid == 1'b0 && devStrobe == 4'd0 && readyClr == 4'd0, "R10 single-cycle",
        {resultValid, devStrobe, readyClr}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0; instValid = 1'b0; instWord = '0; acIn = '0; devReady = '0; devInData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    chk(resultValid == 0 && skipReq == 0 && acOut == 0 && devStrobe == 0 && readyClr == 0 &&
        outData == 0 && genValid == 0 && genDev == 0 && genFunc == 0 && intEnable == 0,
        "R1 reset state", {acOut, outData, genFunc}, 0);
    // full sweep of devices, functions and ready patterns
    for (int d = 0; d < 64; d++)
      for (int f = 0; f < 8; f++)
        for (int k = 0; k < 3; k++) begin
          logic [3:0] rdy;
          logic [11:0] ac;
          int ln;
          ln = (d >= 1 && d <= 4) ? d - 1 : 0;
          rdy = (k == 0) ? 4'd0 : (k == 1) ? (4'd1 << ln) : ~(4'd1 << ln);
          ac = 12'((d * 37 + f * 11 + k * 1500 + 2049) % 4096);
          runOne({3'b110, 6'(d), 3'(f)}, ac, rdy);
        end
    // R2: other opcodes ignored, including ones resembling interrupt control
    runOne(12'o6001, 12'o1234, 4'hF);
    for (int op = 0; op < 8; op++) begin
      if (op == 6) continue;
      runOne({3'(op), 9'o002}, 12'o7777, 4'hF);
      runOne({3'(op), 9'o017}, 12'o0000, 4'hF);
    end
    runOne(12'o6002, 12'o0000, 4'h0);
    for (int op = 0; op < 8; op++) begin
      if (op == 6) continue;
      runOne({3'(op), 9'o001}, 12'o4321, 4'hF);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule